// File: doc/BRIEF.md
# Mode-Configurable Logarithmic Barrel Shifter

This block shifts or rotates a WIDTH-bit word by any amount from 0 to WIDTH-1. The work is done by a chain of log2(WIDTH) stages. Stage k moves its word by 2^k positions when bit k of the amount is set and passes the word through unchanged when it is clear. Four operations are offered: logical left, logical right, arithmetic right and rotate right. The amount, operation and operand are first captured in a command register on a clock edge. The stages are then driven only by a settled command, so glitches on the control inputs never reach the datapath.

A mode selects one of two timing arrangements. In bypass mode the chain after the command register is purely combinational, and a result is ready one cycle after capture. In pipelined mode a register sits behind every stage. This gives a latency of 1+log2(WIDTH) cycles and still accepts a new operation every cycle. The mode can change only while no operation is in flight. A ready output tells the requester when a change will be taken. A per-stage activity vector shows which stages are actually moving data, which is the logical view of which stages could be powered down.

Top module: `log_shifter`

## Requirements
- R1: With in_op = 2'b00 the result is the operand shifted left by in_amt, with zeros entering at bit 0.
- R2: With in_op = 2'b01 the result is the operand shifted right by in_amt, with zeros entering at the top bit.
- R3: With in_op = 2'b10 the result is the operand shifted right by in_amt, with copies of the operand's top bit entering at the top.
- R4: With in_op = 2'b11 the result is the operand rotated right by in_amt, so bits leaving bit 0 re-enter at the top.
- R5: An amount of 0 returns the operand unchanged for every operation, and no stage is reported active.
- R6: In bypass mode (mode_pipe = 0), out_valid and the result appear one cycle after the edge that captures in_valid.
- R7: In pipelined mode (mode_pipe = 1), the result appears 1+log2(WIDTH) cycles after capture. One operation is accepted every cycle, and results leave in issue order.
- R8: stage_active[k] is high exactly when a valid operation is at the input of stage k and bit k of its amount is set. In bypass mode every stage sees the operation held in the command register. In pipelined mode stage k sees an operation k+1 cycles after capture. With nothing present the vector is zero.
- R9: mode_ready is low whenever an operation is held in the command register or in any stage register. A mode request made while mode_ready is low leaves mode_pipe unchanged.
- R10: A request made while mode_ready is high sets mode_pipe to mode_req_pipe on that edge. An operation captured on the same edge runs in the new mode.
- R11: After reset the block is in bypass mode, with out_valid low, mode_ready high and stage_active zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture an operation on this edge |
| in_data | input | WIDTH | Operand |
| in_amt | input | log2(WIDTH) | Shift or rotate amount |
| in_op | input | 2 | Operation: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| mode_req_valid | input | 1 | Request a mode change |
| mode_req_pipe | input | 1 | Requested mode: 1 pipelined, 0 bypass |
| mode_ready | output | 1 | A mode request will be taken on this edge |
| mode_pipe | output | 1 | Current mode: 1 pipelined, 0 bypass |
| out_valid | output | 1 | out_data holds a result |
| out_data | output | WIDTH | Result |
| stage_active | output | log2(WIDTH) | Per-stage activity, bit k for the stage that moves by 2^k |

## Verification
The bench targets the fill behaviour at the largest amount: an arithmetic right shift of a negative word by WIDTH-1 must give all ones, and a rotate must wrap bits to the top. A design that fills with the wrong bit, or treats rotate as a plain shift, shows it directly in the result. It counts the exact cycle at which a pipelined result appears and streams back-to-back operations of mixed kinds. A missing or extra stage register, or a stage that drops or reorders operations, then shows up as a late result or a mismatched sequence. It also follows stage_active stage by stage as a single operation walks down the pipe. It fires a mode request mid-flight and at the exact edge where an operation is captured, which catches a mode register that ignores the in-flight check or that switches too late.

// File: rtl/shf_pkg.sv
package shf_pkg;
    // Operation code carried with each word through the stages
    typedef enum logic [1:0] {
        SHF_SLL = 2'b00,
        SHF_SRL = 2'b01,
        SHF_SRA = 2'b10,
        SHF_ROR = 2'b11
    } shf_op_e;
endpackage

// File: rtl/shf_move.sv
// One power-of-two stage: moves by DIST when en is set, else passes through.
module shf_move #(
    parameter int WIDTH = 16,
    parameter int DIST  = 1
) (
    input  logic              en,
    input  shf_pkg::shf_op_e  op,
    input  logic [WIDTH-1:0]  din,
    output logic [WIDTH-1:0]  dout
);
    import shf_pkg::*;

    logic signed [WIDTH-1:0] sdin;
    logic        [WIDTH-1:0] moved;

    assign sdin = din;

    always_comb begin
        unique case (op)
            SHF_SLL: moved = din << DIST;
            SHF_SRL: moved = din >> DIST;
            SHF_SRA: moved = sdin >>> DIST;
            SHF_ROR: moved = (din >> DIST) | (din << (WIDTH - DIST));
            default: moved = din;
        endcase
        dout = en ? moved : din;
    end
endmodule

// File: rtl/shf_mode_ctrl.sv
// Holds the timing mode; a change is taken only while nothing is in flight.
module shf_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_pipe,
    input  logic busy,
    output logic ready,
    output logic mode_pipe
);
    logic mode_d, mode_q;

    always_comb begin
        ready  = ~busy;
        mode_d = (req_valid && ready) ? req_pipe : mode_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_d;
    end

    assign mode_pipe = mode_q;
endmodule

// File: rtl/log_shifter.sv
module log_shifter #(
    parameter  int WIDTH = 16,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    input  logic [AMT_W-1:0] in_amt,
    input  logic [1:0]       in_op,
    input  logic             mode_req_valid,
    input  logic             mode_req_pipe,
    output logic             mode_ready,
    output logic             mode_pipe,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic [AMT_W-1:0] stage_active
);
    import shf_pkg::*;

    // Command register: the only place raw control inputs are sampled
    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] data;
        logic [AMT_W-1:0] amt;
        shf_op_e          op;
    } cmd_t;

    cmd_t cmd_d, cmd_q;
    logic [AMT_W-1:0] stg_valid;
    logic             busy;

    always_comb begin
        cmd_d       = cmd_q;
        cmd_d.valid = in_valid;
        if (in_valid) begin
            cmd_d.data = in_data;
            cmd_d.amt  = in_amt;
            cmd_d.op   = shf_op_e'(in_op);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    // Stage chain. Stage k only needs amount bits k and above, so the
    // pending amount narrows by one bit per stage.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int RW = AMT_W - k;

        logic             v_in;
        logic [WIDTH-1:0] d_in;
        shf_op_e          op_in;
        logic [RW-1:0]    a_in;
        logic [WIDTH-1:0] d_mv;
        logic             v_d, v_q;
        logic [WIDTH-1:0] d_d, d_q;

        if (k == 0) begin : g_src
            assign v_in  = cmd_q.valid;
            assign d_in  = cmd_q.data;
            assign op_in = cmd_q.op;
            assign a_in  = cmd_q.amt;
        end else begin : g_src
            assign v_in  = mode_pipe ? g_stage[k-1].v_q         : g_stage[k-1].v_in;
            assign d_in  = mode_pipe ? g_stage[k-1].d_q         : g_stage[k-1].d_mv;
            assign op_in = mode_pipe ? g_stage[k-1].g_fwd.op_q  : g_stage[k-1].op_in;
            assign a_in  = mode_pipe ? g_stage[k-1].g_fwd.a_q   : g_stage[k-1].a_in[RW:1];
        end

        shf_move #(
            .WIDTH (WIDTH),
            .DIST  (1 << k)
        ) u_move (
            .en   (a_in[0]),
            .op   (op_in),
            .din  (d_in),
            .dout (d_mv)
        );

        assign stage_active[k] = v_in & a_in[0];

        // Stage register: loads a valid word only in pipelined mode
        always_comb begin
            v_d = mode_pipe & v_in;
            d_d = d_mv;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else begin
                v_q <= v_d;
                d_q <= d_d;
            end
        end

        assign stg_valid[k] = v_q;

        // Operation and remaining amount travel on to the next stage
        if (k < AMT_W - 1) begin : g_fwd
            shf_op_e       op_d, op_q;
            logic [RW-2:0] a_d, a_q;

            always_comb begin
                op_d = op_in;
                a_d  = a_in[RW-1:1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    op_q <= SHF_SLL;
                    a_q  <= '0;
                end else begin
                    op_q <= op_d;
                    a_q  <= a_d;
                end
            end
        end
    end

    assign busy = cmd_q.valid | (|stg_valid);

    shf_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (mode_req_valid),
        .req_pipe  (mode_req_pipe),
        .busy      (busy),
        .ready     (mode_ready),
        .mode_pipe (mode_pipe)
    );

    assign out_valid = mode_pipe ? g_stage[AMT_W-1].v_q : g_stage[AMT_W-1].v_in;
    assign out_data  = mode_pipe ? g_stage[AMT_W-1].d_q : g_stage[AMT_W-1].d_mv;
endmodule

// File: rtl/log_shifter_chk.sv
module log_shifter_chk #(
    parameter int AMT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mode_req_valid,
    input logic             mode_req_pipe,
    input logic             mode_ready,
    input logic             mode_pipe,
    input logic             out_valid,
    input logic [AMT_W-1:0] stage_active
);
    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req_valid && !mode_ready) |=> $stable(mode_pipe));

    // R10
    mode_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req_valid && mode_ready) |=> (mode_pipe == $past(mode_req_pipe)));

    // R6
    bypass_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (mode_pipe || out_valid));

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mode_ready);

    // R8
    idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_pipe && !out_valid) |-> (stage_active == '0));
endmodule

bind log_shifter log_shifter_chk #(.AMT_W(AMT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .mode_req_valid (mode_req_valid),
    .mode_req_pipe  (mode_req_pipe),
    .mode_ready     (mode_ready),
    .mode_pipe      (mode_pipe),
    .out_valid      (out_valid),
    .stage_active   (stage_active)
);

// File: tb/log_shifter_tb.sv
module log_shifter_tb;
    localparam int W = 16;
    localparam int A = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [A-1:0] in_amt = '0;
    logic [1:0]   in_op = '0;
    logic         mode_req_valid = 1'b0;
    logic         mode_req_pipe = 1'b0;
    logic         mode_ready;
    logic         mode_pipe;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic [A-1:0] stage_active;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    log_shifter #(.WIDTH(W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_amt         (in_amt),
        .in_op          (in_op),
        .mode_req_valid (mode_req_valid),
        .mode_req_pipe  (mode_req_pipe),
        .mode_ready     (mode_ready),
        .mode_pipe      (mode_pipe),
        .out_valid      (out_valid),
        .out_data       (out_data),
        .stage_active   (stage_active)
    );

    function automatic logic [W-1:0] model(logic [1:0] op, logic [W-1:0] d, logic [A-1:0] a);
        logic [2*W-1:0] dd;
        case (op)
            2'b00:   return d << a;
            2'b01:   return d >> a;
            2'b10:   return W'($signed(d) >>> a);
            default: begin
                dd = {d, d} >> a;
                return dd[W-1:0];
            end
        endcase
    endfunction

    function automatic string op_tag(logic [1:0] op);
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R11: state during and right after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", 32'(out_valid), 32'd0);
        check("R11", 32'(mode_pipe), 32'd0);
        check("R11", 32'(mode_ready), 32'd1);
        check("R11", 32'(stage_active), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", 32'(out_valid), 32'd0);
        check("R11", 32'(mode_ready), 32'd1);
    endtask

    // One operation in bypass mode: result one cycle after capture
    task automatic run_bypass(input logic [1:0] op, input logic [W-1:0] d,
                              input logic [A-1:0] a, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_data = d; in_amt = a;
        @(negedge clk);
        check("R6", 32'(out_valid), 32'd1);
        check(tag, 32'(out_data), 32'(model(op, d, a)));
        check("R8", 32'(stage_active), 32'(a));
        in_valid = 1'b0;
        @(negedge clk);
        check("R8", 32'(stage_active), 32'd0);
    endtask

    task automatic t_bypass_ops();
        run_bypass(2'b00, 16'h8421, 4'd3,  "R1");
        run_bypass(2'b00, 16'h00F1, 4'd15, "R1");
        run_bypass(2'b01, 16'hF00F, 4'd4,  "R2");
        run_bypass(2'b01, 16'h8000, 4'd15, "R2");
        run_bypass(2'b10, 16'h8F00, 4'd5,  "R3");
        run_bypass(2'b10, 16'h7F00, 4'd9,  "R3");
        run_bypass(2'b10, 16'h8000, 4'd15, "R3");
        run_bypass(2'b11, 16'h1234, 4'd4,  "R4");
        run_bypass(2'b11, 16'h8001, 4'd1,  "R4");
        run_bypass(2'b11, 16'hC35A, 4'd13, "R4");
    endtask

    // R5: zero amount on every operation
    task automatic t_zero_amt();
        for (int op = 0; op < 4; op++)
            run_bypass(2'(op), 16'hA5C3, 4'd0, "R5");
    endtask

    task automatic set_mode(input logic pipe);
        @(negedge clk);
        check("R9", 32'(mode_ready), 32'd1);
        mode_req_valid = 1'b1; mode_req_pipe = pipe;
        @(negedge clk);
        mode_req_valid = 1'b0;
        check("R10", 32'(mode_pipe), 32'(pipe));
    endtask

    // Single pipelined op: latency, per-stage activity, mid-flight request
    task automatic run_pipe_one(input logic [1:0] op, input logic [W-1:0] d, input logic [A-1:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_data = d; in_amt = a;
        for (int c = 1; c <= A + 2; c++) begin
            logic [A-1:0] expv;
            @(negedge clk);
            in_valid = 1'b0;
            expv = '0;
            if (c <= A) begin
                expv[c-1] = a[c-1];
                check("R8", 32'(stage_active), 32'(expv));
            end
            if (c == 2) begin
                check("R9", 32'(mode_ready), 32'd0);
                mode_req_valid = 1'b1; mode_req_pipe = 1'b0;
            end
            if (c == 3) begin
                mode_req_valid = 1'b0;
                check("R9", 32'(mode_pipe), 32'd1);
            end
            if (c == A + 1) begin
                check("R7", 32'(out_valid), 32'd1);
                check(op_tag(op), 32'(out_data), 32'(model(op, d, a)));
            end else begin
                check("R7", 32'(out_valid), 32'd0);
            end
        end
    endtask

    // R7: back-to-back stream of mixed operations
    task automatic t_stream();
        logic [W-1:0] dv [8];
        logic [A-1:0] av [8];
        logic [1:0]   ov [8];
        int got = 0;
        for (int i = 0; i < 8; i++) begin
            dv[i] = W'(16'h9E37 * (i + 3));
            av[i] = A'(i * 5 + 1);
            ov[i] = 2'(i);
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (out_valid) begin
                if (got < 8) check("R7", 32'(out_data), 32'(model(ov[got], dv[got], av[got])));
                got++;
            end
            if (i < 8) begin
                in_valid = 1'b1; in_op = ov[i]; in_data = dv[i]; in_amt = av[i];
            end else begin
                in_valid = 1'b0;
            end
        end
        check("R7", 32'(got), 32'd8);
    endtask

    // R10: switch to bypass on the same edge an operation is captured
    task automatic t_mode_back();
        @(negedge clk);
        check("R9", 32'(mode_ready), 32'd1);
        mode_req_valid = 1'b1; mode_req_pipe = 1'b0;
        in_valid = 1'b1; in_op = 2'b11; in_data = 16'h00FF; in_amt = 4'd8;
        @(negedge clk);
        mode_req_valid = 1'b0; in_valid = 1'b0;
        check("R10", 32'(mode_pipe), 32'd0);
        check("R10", 32'(out_valid), 32'd1);
        check("R10", 32'(out_data), 32'h0000FF00);
    endtask

    initial begin
        t_reset();
        t_bypass_ops();
        t_zero_amt();
        set_mode(1'b1);
        run_pipe_one(2'b10, 16'h9234, 4'd11);
        set_mode(1'b1);
        run_pipe_one(2'b11, 16'h0F0F, 4'd6);
        t_stream();
        t_mode_back();
        run_bypass(2'b01, 16'h4C01, 4'd2, "R2");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule